// File: doc/BRIEF.md
# Prioritized Address Window Translator

This block turns a local-bus address into an address for a PCI-style expansion bus. Three programmable windows are held inside it. Each has a local-side base word (page address, size code and enable) and a bus-side map word (page address, cycle kind and low-bit handling). A request address is compared with every enabled window at once. The lowest-numbered window that matches wins. The block then reports the translated address, the cycle kind and the index of the winning window one clock later. When no window matches, it raises a miss flag and passes no cycle on.

Windows may overlap on purpose. Because window 0 always beats window 1, software can grow window 0 so that it covers the range of window 1. Window 1 is then hidden, and software can reprogram it as a configuration aperture without dropping any memory traffic. Window 2 is wired for I/O cycles only. Software programs the windows through a simple single-cycle write port.

Top module: `addr_window_xlate`

## Requirements
- R1: Reset clears every window. It also holds `xl_valid` and `xl_miss` low until a request arrives, so the first request after reset misses.
- R2: The result of a request on `req_valid`/`req_addr` appears exactly one clock later. In a cycle with no request, both `xl_valid` and `xl_miss` are low.
- R3: Base word bit 0 enables its window. A window whose enable is 0 never matches.
- R4: Base word bits 5:4 choose the window size: 00 = 16 MB, 01 = 256 MB, 10 = 512 MB, 11 = 1 MB.
- R5: Base word bits 31:20 hold the window's local page address. Only the request address bits above the window size are compared with it.
- R6: When several enabled windows match, the lowest-numbered one is used, and its index appears on `xl_win`.
- R7: The translated address takes its bits above the window size from map word bits 31:20. It keeps the request's offset inside the window.
- R8: When map word bit 0 is 1, address bits 1:0 pass through from the request. When it is 0, they are forced to 00.
- R9: For windows 0 and 1, `xl_kind` carries map word bits 3:1 (101 = configuration, 011 = memory, 110 = multiple memory). Window 2 always reports 010 (I/O).
- R10: If no enabled window matches a request, `xl_miss` is 1 and `xl_valid` is 0 one clock later.
- R11: A write with `wr_en` = 1 stores `wr_data` into window `wr_win`. It goes to the map word when `wr_map` = 1 and to the base word otherwise. The new value applies to requests from the next cycle on. A request in the same cycle as the write still sees the old value.
- R12: A write with `wr_win` = 3 (no such window) is ignored and changes no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_win | input | 2 | Window index for the write |
| wr_map | input | 1 | 1 selects the map word, 0 selects the base word |
| wr_data | input | 32 | Write data |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Local address to translate |
| xl_valid | output | 1 | Translated cycle present |
| xl_miss | output | 1 | Request matched no window |
| xl_addr | output | 32 | Translated bus address |
| xl_kind | output | 3 | Cycle kind of the winning window |
| xl_win | output | 2 | Index of the winning window |

## Verification
A window write and a translation request can land in the same clock cycle. The request must be translated with the window contents from before the write, and the next request must use the new contents. The bench provokes this on purpose. It enlarges window 0 with a request in the same cycle, and it disables a window while a request hits it. The random phase also mixes writes and requests in the same cycles. The bench's reference model always evaluates the request before it applies the write, and it compares the translated address, cycle kind, window index and miss flag one cycle later.

// File: rtl/axl_pkg.sv
package axl_pkg;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned PAGE_LSB  = 20;
  localparam int unsigned PAGE_W    = ADDR_W - PAGE_LSB;
  localparam int unsigned NUM_WIN   = 3;
  localparam int unsigned WIN_IDX_W = 2;
  localparam int unsigned IO_WIN    = 2;

  localparam logic [2:0] KIND_IO  = 3'b010;
  localparam logic [2:0] KIND_CFG = 3'b101;

  typedef enum logic [1:0] {
    SZ_16M  = 2'b00,
    SZ_256M = 2'b01,
    SZ_512M = 2'b10,
    SZ_1M   = 2'b11
  } win_size_e;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    win_size_e         size;
    logic              en;
  } base_t;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic [2:0]        kind;
    logic              keep_low;
  } map_t;

  // number of megabyte page bits that lie inside the window
  function automatic int unsigned span_of(win_size_e sz);
    case (sz)
      SZ_16M:  span_of = 4;
      SZ_256M: span_of = 8;
      SZ_512M: span_of = 9;
      default: span_of = 0;
    endcase
  endfunction

  function automatic base_t word_to_base(logic [ADDR_W-1:0] w);
    base_t b;
    b.page = w[ADDR_W-1:PAGE_LSB];
    b.size = win_size_e'(w[5:4]);
    b.en   = w[0];
    return b;
  endfunction

  function automatic map_t word_to_map(logic [ADDR_W-1:0] w);
    map_t m;
    m.page     = w[ADDR_W-1:PAGE_LSB];
    m.kind     = w[3:1];
    m.keep_low = w[0];
    return m;
  endfunction
endpackage

// File: rtl/axl_win_regs.sv
module axl_win_regs
  import axl_pkg::*;
#(
  parameter int unsigned N  = NUM_WIN,
  parameter int unsigned IW = WIN_IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_win,
  input  logic                 wr_map,
  input  logic [ADDR_W-1:0]    wr_data,
  output base_t [N-1:0]        base_q,
  output map_t  [N-1:0]        map_q
);
  base_t [N-1:0] base_d;
  map_t  [N-1:0] map_d;
  logic          wr_hit;

  always_comb begin
    base_d = base_q;
    map_d  = map_q;
    wr_hit = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      if (wr_en && (int'(wr_win) == i)) begin
        wr_hit = 1'b1;
        if (wr_map) map_d[i]  = word_to_map(wr_data);
        else        base_d[i] = word_to_base(wr_data);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      map_q  <= '0;
    end else if (wr_hit) begin
      base_q <= base_d;
      map_q  <= map_d;
    end
  end

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(base_q) && $stable(map_q)));

  // R12
  bad_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(wr_win) >= int'(N))) |=> ($stable(base_q) && $stable(map_q)));
endmodule

// File: rtl/axl_win_match.sv
module axl_win_match
  import axl_pkg::*;
#(
  parameter bit IS_IO = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  base_t             base_q,
  input  map_t              map_q,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] xaddr,
  output logic [2:0]        kind
);
  logic [PAGE_W-1:0] cmp_mask;
  logic [PAGE_W-1:0] addr_page;

  assign addr_page = addr[ADDR_W-1:PAGE_LSB];

  always_comb begin
    cmp_mask = {PAGE_W{1'b1}} << span_of(base_q.size);
    hit      = base_q.en && (((addr_page ^ base_q.page) & cmp_mask) == '0);
    xaddr    = {(map_q.page & cmp_mask) | (addr_page & ~cmp_mask),
                addr[PAGE_LSB-1:2],
                map_q.keep_low ? addr[1:0] : 2'b00};
  end

  generate
    if (IS_IO) begin : g_io
      assign kind = KIND_IO;
    end else begin : g_mem
      assign kind = map_q.kind;
    end
  endgenerate

  // R3
  off_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !base_q.en |-> !hit);

  // R8
  low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !map_q.keep_low |-> (xaddr[1:0] == 2'b00));
endmodule

// File: rtl/axl_prio_select.sv
module axl_prio_select
  import axl_pkg::*;
#(
  parameter int unsigned N  = NUM_WIN,
  parameter int unsigned IW = WIN_IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  hits,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      if (hits[i] && !any) begin
        grant[i] = 1'b1;
        idx      = IW'(i);
        any      = 1'b1;
      end
    end
  end

  // R6
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~hits) == '0));

  // R6
  low_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hits[0] |-> grant[0]);
endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate
  import axl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_win,
  input  logic        wr_map,
  input  logic [31:0] wr_data,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  output logic        xl_valid,
  output logic        xl_miss,
  output logic [31:0] xl_addr,
  output logic [2:0]  xl_kind,
  output logic [1:0]  xl_win
);
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  base_t [NUM_WIN-1:0]           base_q;
  map_t  [NUM_WIN-1:0]           map_q;
  logic  [NUM_WIN-1:0]           hits;
  logic  [NUM_WIN-1:0]           grant;
  logic  [NUM_WIN-1:0][ADDR_W-1:0] w_addr;
  logic  [NUM_WIN-1:0][2:0]      w_kind;
  logic  [WIN_IDX_W-1:0]         sel_idx;
  logic                          sel_any;

  axl_win_regs #(.N(NUM_WIN), .IW(WIN_IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_win(wr_win),
    .wr_map(wr_map), .wr_data(wr_data), .base_q(base_q), .map_q(map_q)
  );

  generate
    for (genvar g = 0; g < int'(NUM_WIN); g++) begin : g_win
      axl_win_match #(.IS_IO(g == int'(IO_WIN))) u_match (
        .clk(clk), .rst_n(rst_int_n), .base_q(base_q[g]), .map_q(map_q[g]),
        .addr(req_addr), .hit(hits[g]), .xaddr(w_addr[g]), .kind(w_kind[g])
      );
    end
  endgenerate

  axl_prio_select #(.N(NUM_WIN), .IW(WIN_IDX_W)) u_prio (
    .clk(clk), .rst_n(rst_int_n), .hits(hits), .grant(grant),
    .idx(sel_idx), .any(sel_any)
  );

  logic                 valid_d, miss_d, load_d;
  logic [ADDR_W-1:0]    addr_d;
  logic [2:0]           kind_d;

  always_comb begin
    valid_d = req_valid && sel_any;
    miss_d  = req_valid && !sel_any;
    load_d  = valid_d;
    addr_d  = '0;
    kind_d  = '0;
    for (int i = 0; i < int'(NUM_WIN); i++) begin
      if (grant[i]) begin
        addr_d = w_addr[i];
        kind_d = w_kind[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      xl_valid <= 1'b0;
      xl_miss  <= 1'b0;
    end else begin
      xl_valid <= valid_d;
      xl_miss  <= miss_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      xl_addr <= '0;
      xl_kind <= '0;
      xl_win  <= '0;
    end else if (load_d) begin
      xl_addr <= addr_d;
      xl_kind <= kind_d;
      xl_win  <= sel_idx;
    end
  end

  // R10
  miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(xl_valid && xl_miss));

  // R2
  out_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (xl_valid || xl_miss) |-> $past(req_valid));

  // R9
  io_kind_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (xl_valid && (xl_win == WIN_IDX_W'(IO_WIN))) |-> (xl_kind == KIND_IO));
endmodule

// File: tb/sim_addr_window_xlate.sv
module sim_addr_window_xlate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_map, req_valid;
  logic [1:0]  wr_win;
  logic [31:0] wr_data, req_addr;
  logic        xl_valid, xl_miss;
  logic [31:0] xl_addr;
  logic [2:0]  xl_kind;
  logic [1:0]  xl_win;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [31:0] mb [0:2];
  logic [31:0] mm [0:2];

  always #4 clk = ~clk;

  addr_window_xlate u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win), .wr_map(wr_map),
    .wr_data(wr_data), .req_valid(req_valid), .req_addr(req_addr),
    .xl_valid(xl_valid), .xl_miss(xl_miss), .xl_addr(xl_addr),
    .xl_kind(xl_kind), .xl_win(xl_win)
  );

  function automatic int unsigned span(logic [1:0] c);
    case (c)
      2'b00: return 4;
      2'b01: return 8;
      2'b10: return 9;
      default: return 0;
    endcase
  endfunction

  // expected result from the requirements (R3..R10)
  function automatic logic [38:0] expect_of(input bit rv, input logic [31:0] a);
    logic [11:0] m;
    logic [31:0] xa;
    logic [2:0]  k;
    if (!rv) return '0;
    for (int i = 0; i < 3; i++) begin
      m = 12'hFFF << span(mb[i][5:4]);
      if (mb[i][0] && (((a[31:20] ^ mb[i][31:20]) & m) == 12'h000)) begin
        xa = {(mm[i][31:20] & m) | (a[31:20] & ~m), a[19:2],
              mm[i][0] ? a[1:0] : 2'b00};
        k  = (i == 2) ? 3'b010 : mm[i][3:1];
        return {1'b1, 1'b0, xa, k, 2'(i)};
      end
    end
    return {1'b0, 1'b1, 37'h0};
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [38:0] act, input logic [38:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge: drives one cycle, checks the result one clock later
  task automatic step(input bit we, input logic [1:0] ww, input bit wm,
                      input logic [31:0] wd, input bit rv, input logic [31:0] ra,
                      input string tag);
    logic [38:0] exp, act;
    wr_en = we; wr_win = ww; wr_map = wm; wr_data = wd;
    req_valid = rv; req_addr = ra;
    exp = expect_of(rv, ra);
    @(posedge clk);
    if (we && ww != 2'd3) begin
      if (wm) mm[ww] = wd; else mb[ww] = wd;
    end
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    act = {xl_valid, xl_miss, xl_addr, xl_kind, xl_win};
    if (exp[38]) check(act == exp, tag, act, exp);
    else         check(act[38:37] == exp[38:37], tag, act, exp);
  endtask

  task automatic wr(input logic [1:0] w, input bit m, input logic [31:0] d);
    step(1'b1, w, m, d, 1'b0, 32'h0, "R11");
  endtask

  task automatic rq(input logic [31:0] a, input string tag);
    step(1'b0, 2'd0, 1'b0, 32'h0, 1'b1, a, tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3; i++) begin mb[i] = '0; mm[i] = '0; end
    rst_n = 1'b0; wr_en = 0; wr_win = 0; wr_map = 0; wr_data = 0;
    req_valid = 0; req_addr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check({xl_valid, xl_miss} == 2'b00, "R1", {37'h0, xl_valid, xl_miss}, 39'h0);
    rq(32'h4000_0000, "R1");
    // R2 idle cycle
    step(1'b0, 0, 0, 0, 1'b0, 32'h4000_0000, "R2");

    // standard layout
    wr(0, 0, 32'h4000_0011);          // 256M at 0x400, enabled
    wr(0, 1, 32'h0000_0006);          // memory
    wr(1, 0, 32'h5000_0011);
    wr(1, 1, 32'h1000_000C);          // multiple memory
    wr(2, 0, 32'h6000_0001);          // 16M
    wr(2, 1, 32'h0000_0001);          // keep low bits
    rq(32'h4123_4567, "R7");
    check(xl_addr == 32'h0123_4564, "R8", {7'h0, xl_addr}, {7'h0, 32'h0123_4564});
    rq(32'h5ABC_DEF3, "R7");
    check(xl_addr == 32'h1ABC_DEF0 && xl_kind == 3'b110, "R9",
          {4'h0, xl_addr, xl_kind}, {4'h0, 32'h1ABC_DEF0, 3'b110});
    rq(32'h60F0_0003, "R9");
    check(xl_addr == 32'h00F0_0003 && xl_kind == 3'b010, "R8",
          {4'h0, xl_addr, xl_kind}, {4'h0, 32'h00F0_0003, 3'b010});
    rq(32'h6100_0000, "R10");
    check(xl_miss && !xl_valid, "R10", {37'h0, xl_valid, xl_miss}, 39'h1);
    rq(32'h3FFF_FFFF, "R5");

    // R11 same-cycle write: grow window 0 to 512M while requesting 0x5...
    step(1'b1, 0, 0, 32'h4000_0021, 1'b1, 32'h5000_1000, "R11");
    check(xl_win == 2'd1, "R11", {37'h0, xl_win}, {37'h0, 2'd1});
    rq(32'h5000_1000, "R6");
    check(xl_win == 2'd0, "R6", {37'h0, xl_win}, 39'h0);
    // reuse hidden window 1 as 16M config aperture
    wr(1, 0, 32'h6100_0001);
    wr(1, 1, 32'h0000_000B);
    rq(32'h6112_3457, "R9");
    check(xl_kind == 3'b101 && xl_addr == 32'h0012_3457, "R9",
          {4'h0, xl_addr, xl_kind}, {4'h0, 32'h0012_3457, 3'b101});
    // R4 1M size
    wr(2, 0, 32'h7000_0031);
    rq(32'h700F_FFFF, "R4");
    rq(32'h7010_0000, "R4");
    // R3 disable window 0 in the same cycle as a hit, then miss next
    step(1'b1, 0, 0, 32'h4000_0020, 1'b1, 32'h4000_0040, "R3");
    rq(32'h4000_0040, "R3");
    check(xl_miss, "R3", {38'h0, xl_miss}, 39'h1);
    // R12 write to index 3 ignored
    step(1'b1, 2'd3, 1'b0, 32'h4000_0011, 1'b0, 32'h0, "R12");
    rq(32'h4000_0040, "R12");
    check(xl_miss, "R12", {38'h0, xl_miss}, 39'h1);

    // constrained random
    for (int n = 0; n < 600; n++) begin
      logic [11:0] pg [0:4];
      logic [31:0] d, a;
      bit we, rv;
      pg[0] = 12'h400; pg[1] = 12'h500; pg[2] = 12'h600;
      pg[3] = 12'h610; pg[4] = 12'h800;
      we = ($urandom % 4) == 0;
      rv = ($urandom % 5) != 0;
      d  = $urandom;
      d[31:20] = pg[$urandom % 5];
      if (($urandom % 4) != 0) d[0] = 1'b1;
      a  = $urandom;
      a[31:20] = pg[$urandom % 5] | 12'($urandom % 2);
      step(we, 2'($urandom), 1'($urandom), d, rv, a, "R6");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule